// File: doc/BRIEF.md
# Seven-to-one LVDS pixel serializer

This block turns a stream of parallel pixels (8-bit red, green and blue plus horizontal sync, vertical sync and data-enable) into seven-bit serial words on up to four data lanes, plus a clock lane that marks each pixel period. It runs from a single fast clock. A slot enable, pulsed at seven times the pixel rate, advances it by one serial slot. Each enabled cycle places one bit on every lane.

A two-bit mapping select chooses how colour and control bits are placed into the slots. Mode 0 is an 18-bit layout on three lanes. Mode 1 is a 24-bit layout with the upper six bits of each colour on lanes 0 to 2 and the two lowest bits on lane 3. Mode 2 is a 24-bit layout with the lower six bits on lanes 0 to 2 and the two top bits on lane 3. Code 3 is reserved and behaves like mode 0.

The pixel inputs and the mapping select are sampled together into a shadow register, once per pixel period. This lets the source change them at any time between captures.

The slot sequencer is a state machine with seven states, SL0 to SL6, one per serial slot. Its transitions are:
- ADVANCE: moves from SLk to SLk+1 on an enabled cycle.
- WRAP: moves from SL6 to SL0 on an enabled cycle, and this is where a new pixel is captured.
- HOLD: stays in the current state when the enable is low.
- RESET: returns the machine to SL0.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: A pixel period is seven enabled cycles, slots 0 to 6. The clock lane shows 1,1,0,0,0,1,1 in slots 0 to 6, so its only falling edge comes on entering slot 2.
- R2: In mode 0, lane 0 shows G2,R7,R6,R5,R4,R3,R2 in slots 0..6. Lane 1 shows B3,B2,G7,G6,G5,G4,G3. Lane 2 shows DE,VS,HS,B7,B6,B5,B4.
- R3: In mode 0, lane 3 stays 0 and input colour bits 1 and 0 have no effect on any lane.
- R4: In mode 1, lanes 0 to 2 match R2. Lane 3 shows 0,B1,B0,G1,G0,R1,R0 in slots 0..6.
- R5: In mode 2, lane 0 shows G0,R5..R0, lane 1 shows B1,B0,G5..G1, and lane 2 shows DE,VS,HS,B5..B2. Lane 3 shows 0,B7,B6,G7,G6,R7,R6.
- R6: Slot 0 of lane 3 is always 0. The control slots of lane 2 carry data-enable in slot 0, vertical sync in slot 1 and horizontal sync in slot 2.
- R7: The mapping select is sampled only when a new pixel is captured. A change during a pixel period applies from the next pixel.
- R8: The pixel inputs are captured on the enabled cycle that leaves slot 6, and their slot-0 bits appear on that same edge. Later input changes within the period have no effect on it.
- R9: A cycle with the slot enable low changes neither the lanes, the clock lane nor the slot position.
- R10: Synchronous active-high reset drives all data lanes and the clock lane to 0, returns to slot 0 and clears the shadow pixel to zero in mode 0. The first enabled cycle afterwards shows slot 1 of that zero pixel.
- R11: Mapping select code 3 produces exactly the mode 0 output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Advances one serial slot when high |
| map_sel | input | 2 | Mapping select: 0 18-bit, 1 24-bit upper-first, 2 24-bit lower-first, 3 as 0 |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| lane_out | output | 4 | Serial data lanes, bit n is lane n |
| clk_lane | output | 1 | Clock-lane pattern |

## Verification
Every lane bit and the clock-lane bit are registered. Each one is therefore due on the edge of the enabled cycle that selects its slot, including slot 0, which shows a pixel captured on that very edge. The bench drives inputs on the falling edge and samples one half-cycle after the rising edge. It advances its own slot and capture model exactly once per enabled cycle. Reset takes effect on the first rising edge it is high, and a disabled cycle is expected to leave the previously sampled value in place.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
    localparam int COLOR_W   = 8;
    localparam int NUM_LANES = 4;
    localparam int NUM_SLOTS = 7;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int SUB_W     = 6;

    typedef enum logic [1:0] {
        MAP_18   = 2'd0,
        MAP_24HI = 2'd1,
        MAP_24LO = 2'd2,
        MAP_RSV  = 2'd3
    } map_mode_e;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
        logic               hs;
        logic               vs;
        logic               de;
    } pixel_t;

    typedef logic [NUM_SLOTS-1:0] slot_word_t;

    // clock-lane pattern, bit index = slot
    localparam slot_word_t CLK_PATTERN = 7'b1100011;

    // lane words, bit index = slot
    function automatic logic [NUM_LANES-1:0][NUM_SLOTS-1:0] build_words(
        input pixel_t    px,
        input map_mode_e md
    );
        logic [NUM_LANES-1:0][NUM_SLOTS-1:0] w;
        logic [SUB_W-1:0] r6, g6, b6;
        if (md == MAP_24LO) begin
            r6 = px.r[SUB_W-1:0];
            g6 = px.g[SUB_W-1:0];
            b6 = px.b[SUB_W-1:0];
        end else begin
            r6 = px.r[COLOR_W-1:COLOR_W-SUB_W];
            g6 = px.g[COLOR_W-1:COLOR_W-SUB_W];
            b6 = px.b[COLOR_W-1:COLOR_W-SUB_W];
        end
        w[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
        w[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
        w[2] = {b6[2], b6[3], b6[4], b6[5], px.hs, px.vs, px.de};
        unique case (md)
            MAP_24HI: w[3] = {px.r[0], px.r[1], px.g[0], px.g[1],
                              px.b[0], px.b[1], 1'b0};
            MAP_24LO: w[3] = {px.r[6], px.r[7], px.g[6], px.g[7],
                              px.b[6], px.b[7], 1'b0};
            default:  w[3] = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/lvds_slot_fsm.sv
module lvds_slot_fsm
    import lvds_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_en,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [SLOT_W-1:0] next_slot,
    output logic              wrap
);
    typedef enum logic [SLOT_W-1:0] {
        SL0 = 3'd0, SL1 = 3'd1, SL2 = 3'd2, SL3 = 3'd3,
        SL4 = 3'd4, SL5 = 3'd5, SL6 = 3'd6
    } slot_state_e;

    slot_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SL0;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        wrap    = 1'b0;
        unique case (state_q)
            SL0: if (slot_en) state_d = SL1;
            SL1: if (slot_en) state_d = SL2;
            SL2: if (slot_en) state_d = SL3;
            SL3: if (slot_en) state_d = SL4;
            SL4: if (slot_en) state_d = SL5;
            SL5: if (slot_en) state_d = SL6;
            SL6: if (slot_en) begin
                state_d = SL0;
                wrap    = 1'b1;
            end
            default: state_d = SL0;
        endcase
        cur_slot  = state_q;
        next_slot = state_d;
    end
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
    import lvds_ser_pkg::*;
(
    input  pixel_t                 px,
    input  map_mode_e              mode,
    input  logic [SLOT_W-1:0]      slot,
    output logic [NUM_LANES-1:0]   lane_bits,
    output logic                   clk_bit
);
    logic [NUM_LANES-1:0][NUM_SLOTS-1:0] words;

    assign words   = build_words(px, mode);
    assign clk_bit = CLK_PATTERN[slot];

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        assign lane_bits[ln] = words[ln][slot];
    end
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
    import lvds_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_en,
    input  logic [1:0]         map_sel,
    input  logic [COLOR_W-1:0] pix_r,
    input  logic [COLOR_W-1:0] pix_g,
    input  logic [COLOR_W-1:0] pix_b,
    input  logic               pix_hs,
    input  logic               pix_vs,
    input  logic               pix_de,
    output logic [NUM_LANES-1:0] lane_out,
    output logic               clk_lane
);
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              wrap;
    pixel_t            in_pix, act_pix_q, src_pix;
    map_mode_e         act_mode_q, src_mode;
    logic [NUM_LANES-1:0] lane_d;
    logic              clk_d;

    assign in_pix = '{r: pix_r, g: pix_g, b: pix_b,
                      hs: pix_hs, vs: pix_vs, de: pix_de};

    lvds_slot_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .slot_en   (slot_en),
        .cur_slot  (slot_q),
        .next_slot (slot_d),
        .wrap      (wrap)
    );

    // on WRAP the fresh pixel feeds slot 0 directly
    always_comb begin
        src_pix  = wrap ? in_pix : act_pix_q;
        src_mode = wrap ? map_mode_e'(map_sel) : act_mode_q;
    end

    lvds_lane_mapper u_map (
        .px        (src_pix),
        .mode      (src_mode),
        .slot      (slot_d),
        .lane_bits (lane_d),
        .clk_bit   (clk_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_pix_q  <= '0;
            act_mode_q <= MAP_18;
            lane_out   <= '0;
            clk_lane   <= 1'b0;
        end else if (slot_en) begin
            if (wrap) begin
                act_pix_q  <= in_pix;
                act_mode_q <= map_mode_e'(map_sel);
            end
            lane_out <= lane_d;
            clk_lane <= clk_d;
        end
    end
endmodule

// File: rtl/lvds_ser_checker.sv
module lvds_ser_checker
    import lvds_ser_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 slot_en,
    input logic [SLOT_W-1:0]    slot,
    input map_mode_e            act_mode,
    input logic [NUM_LANES-1:0] lane_out,
    input logic                 clk_lane
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (lane_out == '0 && !clk_lane && slot == '0)); // R10

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> ($stable(lane_out) && $stable(clk_lane) && $stable(slot))); // R9

    AST_CLK_FALL_SLOT2: assert property (@(posedge clk) disable iff (rst)
        ($fell(clk_lane) && !$past(rst)) |-> (slot == 3'd2)); // R1

    AST_SLOT0_LANE3_ZERO: assert property (@(posedge clk) disable iff (rst)
        (slot == '0) |-> !lane_out[3]); // R6

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!slot_en || slot != 3'd6) |=> $stable(act_mode)); // R7

    AST_18BIT_LANE3_IDLE: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MAP_18 || act_mode == MAP_RSV) |-> !lane_out[3]); // R3
endmodule

bind lvds_pixel_serializer lvds_ser_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .slot_en  (slot_en),
    .slot     (slot_q),
    .act_mode (act_mode_q),
    .lane_out (lane_out),
    .clk_lane (clk_lane)
);

// File: tb/lvds_pixel_serializer_tb.sv
module lvds_pixel_serializer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_en = 1'b0;
    logic [1:0] map_sel = 2'd0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
    logic [3:0] lane_out;
    logic       clk_lane;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lvds_pixel_serializer u_dut (
        .clk(clk), .rst(rst), .slot_en(slot_en), .map_sel(map_sel),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
        .lane_out(lane_out), .clk_lane(clk_lane)
    );

    // {mode, r, g, b, hs, vs, de}
    localparam logic [28:0] TBL [0:7] = '{
        {2'd0, 8'hA7, 8'h3C, 8'hF2, 1'b1, 1'b0, 1'b1},
        {2'd1, 8'h5A, 8'hC3, 8'h96, 1'b0, 1'b1, 1'b1},
        {2'd2, 8'hE1, 8'h1E, 8'hB4, 1'b1, 1'b1, 1'b0},
        {2'd3, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1},
        {2'd1, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0},
        {2'd2, 8'h81, 8'h42, 8'h24, 1'b0, 1'b0, 1'b1},
        {2'd0, 8'hFC, 8'hFC, 8'hFC, 1'b1, 1'b1, 1'b1},
        {2'd2, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1}
    };

    logic [28:0] act_v;
    int          bslot;
    logic [4:0]  last_exp;

    // returns {clk, l3, l2, l1, l0}
    function automatic logic [4:0] model(input logic [28:0] v, input int s);
        logic [1:0] m;
        logic [7:0] r, g, b;
        logic hs, vs, de, c, l0, l1, l2, l3;
        {m, r, g, b, hs, vs, de} = v;
        c = (s == 0 || s == 1 || s == 5 || s == 6);
        if (m == 2'd2) begin
            case (s)
                0: {l0, l1, l2, l3} = {g[0], b[1], de,   1'b0};
                1: {l0, l1, l2, l3} = {r[5], b[0], vs,   b[7]};
                2: {l0, l1, l2, l3} = {r[4], g[5], hs,   b[6]};
                3: {l0, l1, l2, l3} = {r[3], g[4], b[5], g[7]};
                4: {l0, l1, l2, l3} = {r[2], g[3], b[4], g[6]};
                5: {l0, l1, l2, l3} = {r[1], g[2], b[3], r[7]};
                default: {l0, l1, l2, l3} = {r[0], g[1], b[2], r[6]};
            endcase
        end else begin
            case (s)
                0: {l0, l1, l2, l3} = {g[2], b[3], de,   1'b0};
                1: {l0, l1, l2, l3} = {r[7], b[2], vs,   b[1]};
                2: {l0, l1, l2, l3} = {r[6], g[7], hs,   b[0]};
                3: {l0, l1, l2, l3} = {r[5], g[6], b[7], g[1]};
                4: {l0, l1, l2, l3} = {r[4], g[5], b[6], g[0]};
                5: {l0, l1, l2, l3} = {r[3], g[4], b[5], r[1]};
                default: {l0, l1, l2, l3} = {r[2], g[3], b[4], r[0]};
            endcase
            if (m != 2'd1) l3 = 1'b0;
        end
        return {c, l3, l2, l1, l0};
    endfunction

    function automatic string tag_of(input logic [28:0] v);
        case (v[28:27])
            2'd0:    return "R2 R3 R6 R8";
            2'd1:    return "R4 R6 R7 R8";
            2'd2:    return "R5 R6 R7 R8";
            default: return "R11 R7";
        endcase
    endfunction

    task automatic check(input logic [4:0] exp, input string tag);
        checks++;
        if ({clk_lane, lane_out} !== exp) begin
            errors++;
            $display("FAIL %s R1 slot %0d: got %b expected %b", tag, bslot,
                     {clk_lane, lane_out}, exp);
        end
    endtask

    task automatic drive(input logic [28:0] v);
        {map_sel, pix_r, pix_g, pix_b, pix_hs, pix_vs, pix_de} = v;
    endtask

    // one enabled cycle; returns 1 when a capture happened
    task automatic step(output bit captured);
        captured = 1'b0;
        slot_en = 1'b1;
        if (bslot == 6) begin
            act_v = {map_sel, pix_r, pix_g, pix_b, pix_hs, pix_vs, pix_de};
            bslot = 0;
            captured = 1'b1;
        end else begin
            bslot++;
        end
        @(posedge clk);
        @(negedge clk);
        slot_en = 1'b0;
        last_exp = model(act_v, bslot);
        check(last_exp, tag_of(act_v));
    endtask

    task automatic run_until_capture();
        bit cap;
        do step(cap); while (!cap);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        slot_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        slot_en = 1'b0;
        act_v = '0;
        bslot = 0;
        checks++;
        if ({clk_lane, lane_out} !== 5'b0) begin
            errors++;
            $display("FAIL R10 reset: got %b expected 00000", {clk_lane, lane_out});
        end
    endtask

    initial begin
        bit cap;
        act_v = '0;
        bslot = 0;
        @(negedge clk);
        @(negedge clk);
        do_reset();                       // R10 reset state
        step(cap);                        // R10 first step shows slot 1, clock high
        checks++;
        if ({clk_lane, lane_out} !== 5'b10000) begin
            errors++;
            $display("FAIL R10 post-reset step: got %b expected 10000", {clk_lane, lane_out});
        end

        // table walk: each entry is captured, then the next is driven mid-pixel (R7, R8)
        for (int i = 0; i < 8; i++) begin
            drive(TBL[i]);
            run_until_capture();
        end
        drive(29'd0);
        run_until_capture();

        // R9: stall mid-pixel with changing inputs
        drive(TBL[1]);
        run_until_capture();
        drive(TBL[2]);
        step(cap);
        step(cap);
        for (int k = 0; k < 3; k++) begin
            drive(TBL[k + 3]);
            @(posedge clk);
            @(negedge clk);
            checks++;
            if ({clk_lane, lane_out} !== last_exp) begin
                errors++;
                $display("FAIL R9 stall: got %b expected %b", {clk_lane, lane_out}, last_exp);
            end
        end
        drive(TBL[2]);
        run_until_capture();

        // R10: reset in the middle of a pixel
        step(cap);
        step(cap);
        do_reset();
        step(cap);
        checks++;
        if ({clk_lane, lane_out} !== 5'b10000) begin
            errors++;
            $display("FAIL R10 mid-run reset: got %b expected 10000", {clk_lane, lane_out});
        end
        drive(TBL[3]);
        run_until_capture();
        drive(TBL[0]);
        run_until_capture();
        run_until_capture();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule